// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a small register file that a remote master reaches over four wires: a serial clock, a data-in line, a data-out line and an active-low strobe. The block runs on a fast system clock. It passes all three incoming serial lines through synchronizers and finds the serial clock edges in the system clock domain. The master shifts a frame in on data-in, most significant bit first. It then ends the frame with a single serial clock pulse during which the strobe is low. The data-in level during that pulse tells the block whether the frame is a write or a read.

A write frame carries 32 data bits followed by 8 address bits. A read frame carries only the 8 address bits. After a read, the master gives 32 more serial clocks and collects the register value on data-out, MSB first. The block holds two writable 32-bit registers: a mode word and a routing word. It also presents two values that come from outside the block: a bank of switch inputs and a fixed version word. A write of 1 to the reset location produces a one-cycle system reset request. The link has no back-pressure and no valid/ready handshake, so the master alone paces every transfer. The system clock must run at least four times as fast as the serial clock.

Top module: `sreg_slave`

## Requirements
- R1: While the strobe is high, each rising serial clock edge shifts the data-in level into the frame, MSB first.
- R2: A rising serial clock edge with the strobe low ends the frame. If data-in is 1 on that edge, the frame is a write: the last 40 captured bits hold the data in bits 39..8 and the address in bits 7..0.
- R3: If data-in is 0 on the frame-ending edge, the frame is a read of the address held in the last 8 captured bits. The block drives the register's MSB on data-out after the falling serial edge that closes the strobe pulse, and moves to the next lower bit on each later falling edge. After all 32 bits, data-out returns to 0. Data-out changes on the third system clock edge after the serial falling edge reaches the pin.
- R4: Address 0x00 (mode) and address 0x02 (routing) can be written and read back.
- R5: Address 0x08 returns the switch inputs and address 0xFF returns the version input, both sampled when the read command is taken. Writes to these two addresses change no register.
- R6: A read of any address outside the five used addresses returns 0. A write to such an address changes no register.
- R7: A write to address 0x80 with data bit 0 set raises the reset request for exactly one system clock cycle, starting on the fourth system clock edge after the frame-ending serial edge reaches the pin. A write with bit 0 clear raises nothing. A read of 0x80 returns 0.
- R8: After reset, data-out and the reset request are 0, and the mode and routing registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the master |
| ser_din_i | input | 1 | Serial data from the master, MSB first |
| ser_stb_n_i | input | 1 | Active-low frame-ending strobe, idles high |
| ser_dout_o | output | 1 | Serial read data to the master, MSB first |
| switch_i | input | 32 | External switch bank, read at 0x08 |
| version_i | input | 32 | Fixed version word, read at 0xFF |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
Two functions can act on the same serial clocks. While the 32 read bits leave on data-out, the master can already be shifting the next write frame in on data-in, so the output shifter and the input frame register move on the same edges. The bench provokes this by sending the data part of a write as the din stream during a read. It then adds only the address bits and the write strobe. Each system clock, a behavioural model compares data-out and the reset request. The model then checks that the read value was correct and that the overlapped write landed in the right register.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;

  localparam logic [7:0] LOC_MODE    = 8'h00;
  localparam logic [7:0] LOC_ROUTE   = 8'h02;
  localparam logic [7:0] LOC_SWITCH  = 8'h08;
  localparam logic [7:0] LOC_RESET   = 8'h80;
  localparam logic [7:0] LOC_VERSION = 8'hFF;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_ROUTE, SEL_SWITCH, SEL_RESET, SEL_VERSION
  } reg_sel_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int unsigned LINES  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
        else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              din,
  input  logic              stb_n,
  output logic              wr_pulse,
  output logic              rd_pulse,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int unsigned FRAME_W = DATA_W + ADDR_W;

  logic [FRAME_W-1:0] shreg;
  logic               cmd_edge;

  assign cmd_edge = sclk_rise & ~stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      wr_pulse <= 1'b0;
      rd_pulse <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      wr_pulse <= 1'b0;
      rd_pulse <= 1'b0;
      if (cmd_edge) begin
        wr_pulse <= din;
        rd_pulse <= ~din;
        cmd_addr <= shreg[ADDR_W-1:0];
        cmd_data <= shreg[FRAME_W-1:ADDR_W];
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], din};
      end
    end
  end

  // A command yields at most one decoded pulse per frame-ending edge
  assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse || rd_pulse) |=> !(wr_pulse || rd_pulse));
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_MODE    = ADDR_W'(LOC_MODE),
  parameter logic [ADDR_W-1:0] A_ROUTE   = ADDR_W'(LOC_ROUTE),
  parameter logic [ADDR_W-1:0] A_SWITCH  = ADDR_W'(LOC_SWITCH),
  parameter logic [ADDR_W-1:0] A_RESET   = ADDR_W'(LOC_RESET),
  parameter logic [ADDR_W-1:0] A_VERSION = ADDR_W'(LOC_VERSION)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic              rd_pulse,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] switch_i,
  input  logic [DATA_W-1:0] version_i,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] route_q;

  always_comb begin
    if      (cmd_addr == A_MODE)    sel = SEL_MODE;
    else if (cmd_addr == A_ROUTE)   sel = SEL_ROUTE;
    else if (cmd_addr == A_SWITCH)  sel = SEL_SWITCH;
    else if (cmd_addr == A_RESET)   sel = SEL_RESET;
    else if (cmd_addr == A_VERSION) sel = SEL_VERSION;
    else                            sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      route_q   <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= wr_pulse && (sel == SEL_RESET) && cmd_data[0];
      if (wr_pulse && sel == SEL_MODE)  mode_q  <= cmd_data;
      if (wr_pulse && sel == SEL_ROUTE) route_q <= cmd_data;
    end
  end

  always_comb begin
    case (sel)
      SEL_MODE:    rd_data = mode_q;
      SEL_ROUTE:   rd_data = route_q;
      SEL_SWITCH:  rd_data = switch_i;
      SEL_VERSION: rd_data = version_i;
      default:     rd_data = '0;
    endcase
  end

  assign rd_load = rd_pulse;

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  assert_mode_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && cmd_addr == A_MODE) |=> mode_q == $past(cmd_data));
  assert_ro_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && (cmd_addr == A_SWITCH || cmd_addr == A_VERSION))
      |=> ($stable(mode_q) && $stable(route_q)));
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_fall,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              dout
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] buf_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      left_q <= '0;
      dout   <= 1'b0;
    end else if (load) begin
      buf_q  <= load_data;
      left_q <= CNT_W'(DATA_W);
    end else if (sclk_fall) begin
      if (left_q != '0) begin
        dout   <= buf_q[DATA_W-1];
        buf_q  <= {buf_q[DATA_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end else begin
        dout <= 1'b0;
      end
    end
  end

  assert_tail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && !load && left_q == '0) |=> !dout);
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  input  logic              ser_stb_n_i,
  output logic              ser_dout_o,
  input  logic [DATA_W-1:0] switch_i,
  input  logic [DATA_W-1:0] version_i,
  output logic              reset_req_o
);
  localparam int unsigned N_LINES = 3;

  logic [N_LINES-1:0] raw, synced;
  logic               sclk_d, sclk_rise, sclk_fall;
  logic               wr_pulse, rd_pulse, rd_load;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [DATA_W-1:0]  cmd_data, rd_data;

  assign raw = {ser_din_i, ser_stb_n_i, ser_clk_i};

  sreg_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= synced[0];
  end

  assign sclk_rise = synced[0] & ~sclk_d;
  assign sclk_fall = ~synced[0] & sclk_d;

  assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);

  sreg_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .din(synced[2]),
    .stb_n(synced[1]), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  sreg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .switch_i(switch_i),
    .version_i(version_i), .rd_load(rd_load), .rd_data(rd_data),
    .reset_req(reset_req_o)
  );

  sreg_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .load(rd_load),
    .load_data(rd_data), .dout(ser_dout_o)
  );
endmodule

// File: tb/tb_sreg_slave.sv
module tb_sreg_slave;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, din = 1'b0, stb_n = 1'b1;
  logic [31:0] sw = 32'h0000_3C5A, ver = 32'hA5C3_0F1E;
  logic        dout, rreq;

  always #2 clk = ~clk;

  sreg_slave dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_din_i(din),
    .ser_stb_n_i(stb_n), .ser_dout_o(dout), .switch_i(sw),
    .version_i(ver), .reset_req_o(rreq)
  );

  int   n_chk = 0, n_fail = 0;
  bit   done = 0, cmp_on = 0;
  logic [31:0] m_mode = '0, m_route = '0;
  logic mdl_dout = 1'b0, mdl_rst = 1'b0;
  logic [2:0] dpipe = '0;
  logic [3:0] rpipe = '0;

  // Reference model delay: data-out 3 system edges, reset request 4
  always @(posedge clk) begin
    dpipe <= {dpipe[1:0], mdl_dout};
    rpipe <= {rpipe[2:0], mdl_rst};
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_chk++;
      if (dout !== dpipe[2]) begin
        n_fail++;
        $display("FAIL R3 data-out per-clock actual=%0b expected=%0b t=%0t", dout, dpipe[2], $time);
      end
      n_chk++;
      if (rreq !== rpipe[3]) begin
        n_fail++;
        $display("FAIL R7 reset request per-clock actual=%0b expected=%0b t=%0t", rreq, rpipe[3], $time);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_mode;
      8'h02:   return m_route;
      8'h08:   return sw;
      8'hFF:   return ver;
      default: return 32'h0;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bit(input logic b);
    din = b;
    tick(H);
    sclk = 1'b1;
    tick(H);
    sclk = 1'b0;
  endtask

  task automatic strobe(input logic op, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rv);
    rv = '0;
    din = op;
    stb_n = 1'b0;
    tick(H);
    sclk = 1'b1;
    if (op) begin
      if (a == 8'h00) m_mode = d;
      if (a == 8'h02) m_route = d;
      if (a == 8'h80 && d[0]) begin
        mdl_rst = 1'b1;
        tick(1);
        mdl_rst = 1'b0;
        tick(H - 1);
      end else tick(H);
    end else begin
      rv = model_read(a);
      tick(H);
    end
    sclk = 1'b0;
    if (!op) mdl_dout = rv[31];
    tick(H);
    stb_n = 1'b1;
    din = 1'b0;
    tick(1);
  endtask

  task automatic write_tail(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] unused_rv;
    for (int i = 7; i >= 0; i--) shift_bit(a[i]);
    strobe(1'b1, a, d, unused_rv);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
    for (int i = 31; i >= 0; i--) shift_bit(d[i]);
    write_tail(a, d);
  endtask

  task automatic read_reg(input logic [7:0] a, input logic [31:0] stream,
                          output logic [31:0] got, output logic [31:0] exp);
    for (int i = 7; i >= 0; i--) shift_bit(a[i]);
    strobe(1'b0, a, 32'h0, exp);
    got = '0;
    for (int i = 31; i >= 0; i--) begin
      din = stream[i];
      tick(H);
      got[i] = dout;
      sclk = 1'b1;
      tick(H);
      sclk = 1'b0;
      mdl_dout = (i > 0) ? exp[i-1] : 1'b0;
    end
    din = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R8: reset state at the ports
    chk("R8 data-out after reset", {31'h0, dout}, 32'h0);
    chk("R8 reset request after reset", {31'h0, rreq}, 32'h0);
    cmp_on = 1;

    read_reg(8'h00, 32'h0, got, exp);
    chk("R8 mode after reset", got, 32'h0);
    read_reg(8'h02, 32'h0, got, exp);
    chk("R8 routing after reset", got, 32'h0);

    // R5: external values
    read_reg(8'hFF, 32'h0, got, exp);
    chk("R5 version read", got, 32'hA5C3_0F1E);
    read_reg(8'h08, 32'h0, got, exp);
    chk("R5 switch read", got, 32'h0000_3C5A);

    // R1 R2 R4: write and read back, asymmetric patterns
    write_reg(8'h00, 32'h1234_5678);
    read_reg(8'h00, 32'h0, got, exp);
    chk("R4 R1 mode readback", got, 32'h1234_5678);
    write_reg(8'h02, 32'h8000_0001);
    read_reg(8'h02, 32'hFFFF_FFFF, got, exp);
    chk("R4 R2 routing readback", got, 32'h8000_0001);

    // R5: writes to read-only locations ignored
    write_reg(8'h08, 32'hFFFF_0000);
    write_reg(8'hFF, 32'h0BAD_F00D);
    read_reg(8'h08, 32'h0, got, exp);
    chk("R5 switch after write", got, 32'h0000_3C5A);
    read_reg(8'hFF, 32'h0, got, exp);
    chk("R5 version after write", got, 32'hA5C3_0F1E);
    read_reg(8'h00, 32'h0, got, exp);
    chk("R5 mode unchanged by read-only write", got, 32'h1234_5678);

    // R6: unmapped
    write_reg(8'h10, 32'h5555_AAAA);
    read_reg(8'h10, 32'h0, got, exp);
    chk("R6 unmapped read", got, 32'h0);
    read_reg(8'h01, 32'h0, got, exp);
    chk("R6 unmapped read 0x01", got, 32'h0);
    read_reg(8'h02, 32'h0, got, exp);
    chk("R6 routing unchanged by unmapped write", got, 32'h8000_0001);

    // R7: reset request
    write_reg(8'h80, 32'h0000_0001);
    write_reg(8'h80, 32'h0000_0002);
    read_reg(8'h80, 32'h0, got, exp);
    chk("R7 reset location reads zero", got, 32'h0);

    // R3: read data out while next write frame streams in
    read_reg(8'h00, 32'hDEAD_BEEF, got, exp);
    chk("R3 overlapped read value", got, 32'h1234_5678);
    write_tail(8'h02, 32'hDEAD_BEEF);
    read_reg(8'h02, 32'h0, got, exp);
    chk("R3 R2 overlapped write landed", got, 32'hDEAD_BEEF);

    // R5: switch sampled at read time
    sw = 32'hC001_0FF0;
    tick(4);
    read_reg(8'h08, 32'h0, got, exp);
    chk("R5 switch follows input", got, 32'hC001_0FF0);

    tick(10);
    done = 1;
    summary();
    $finish;
  end
endmodule